// File: doc/BRIEF.md
# Programming-Cycle Ready/Busy Sequencer

This block handles the part of a serial EEPROM write that follows the command. The memory has one shared line for data in and data out. A separate command shifter first shifts in a write, erase, write-all or erase-all command. The host then pulses `startReq`, and the sequencer takes over the select and clock pins.

The sequencer holds select low for a configured minimum time, which starts the self-timed programming cycle inside the memory. It then raises select. With select high, the memory drives its status onto the shared line: 0 means busy, 1 means ready. The sequencer polls the line until it reads 1. It then gives one clock pulse with select still high, which silences the status driver so that nothing is left driving the line. Finally it drops select and reports completion with a one-cycle `doneStrobe`.

If ready is not seen within a programmable number of poll cycles, the sequence is abandoned and `timeoutFlag` is set. After reset, before any command is accepted, the block gives the same status-silencing pulse once, because the status driver of the memory may be active at power-up. All times are counted in system clock cycles. The host's own line driver may drive only while `lineEn` is high, and `lineEn` is high only while the sequencer is idle.

Top module: `prog_cycle_seq`

## Requirements
- R1: While `rstN` is low, `selOut`, `clkOut`, `lineEn`, `doneStrobe` and `timeoutFlag` are all 0.
- R2: After reset is released, the following happens before `lineEn` first rises:
  - select is raised for `cfgPulse` cycles with the clock low;
  - the clock is then high for `cfgPulse` cycles;
  - it is then low for `cfgPulse` cycles with select still high;
  - select then drops, and no `doneStrobe` is given.
- R3: A `startReq` seen while idle makes select stay low for exactly `cfgSelLow` cycles after the accepting edge. Select then rises.
- R4: Once select rises, the block polls. The clock stays low during polling, and polling ends on the first cycle in which `lineIn` is sampled as 1. When ready is seen on the last allowed poll cycle, it takes precedence over the timeout.
- R5: After ready is seen, exactly one clock pulse is given:
  - the clock is high for `cfgPulse` cycles with select high;
  - it is then low for `cfgPulse` cycles with select still high;
  - select then drops.
- R6: `doneStrobe` is high for exactly one cycle, in the first cycle after the sequence in which select is low and `lineEn` is high.
- R7: If `lineIn` stays 0 for `cfgTimeout` poll cycles:
  - select drops with no clock pulse;
  - `doneStrobe` and `timeoutFlag` rise together;
  - `timeoutFlag` stays high until the next accepted `startReq`, which clears it.
- R8: `lineEn` is 1 only while the sequencer is idle, and never while select or the clock is high.
- R9: `startReq` has no effect while a sequence or the power-up pulse is running.
- R10: A configuration value of 0 for `cfgSelLow`, `cfgPulse` or `cfgTimeout` acts as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to run the programming-cycle sequence, taken only when idle |
| cfgSelLow | input | CNT_W | Minimum select-low time in cycles |
| cfgPulse | input | CNT_W | Clock pulse high time, and low time, in cycles |
| cfgTimeout | input | TOUT_W | Poll limit in cycles |
| lineIn | input | 1 | Shared data line as received from the memory |
| selOut | output | 1 | Chip select to the memory, active high |
| clkOut | output | 1 | Serial clock to the memory |
| lineEn | output | 1 | Permission for the host driver to drive the shared line |
| doneStrobe | output | 1 | One-cycle completion pulse |
| timeoutFlag | output | 1 | Set when polling gave up, cleared by the next start |

## Verification
Some rules are checked on every cycle:
- the clock is never high without select;
- `lineEn` never overlaps select;
- the done pulse lasts one cycle and lands with select low;
- a timeout always comes with a done pulse;
- a select-low window never ends before its count is reached;
- a ready sample in polling always leads straight into the clock pulse;
- no state other than idle can start a new select-low phase.

Other properties depend on the exact numbers of cycles, and only the bench scenarios can show them. These are the exact phase lengths for given settings, the power-up pulse, the ready-versus-timeout priority on the last poll cycle, clearing the flag on a new start, and zero settings acting as one.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_PWR_SET,
    ST_IDLE,
    ST_SEL_LOW,
    ST_POLL,
    ST_CLK_HI,
    ST_CLK_LO
  } seq_state_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic cntClr;
    logic doneSet;
    logic toutSet;
    logic toutClr;
  } seq_ctrl_t;

endpackage

// File: rtl/prog_seq_dp.sv
module prog_seq_dp
  import prog_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TOUT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctrl_t         ctrl,
  input  logic [CNT_W-1:0]  cfgSelLow,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [TOUT_W-1:0] cfgTimeout,
  output logic              hitSel,
  output logic              hitPulse,
  output logic              hitTout,
  output logic              doneStrobe,
  output logic              timeoutFlag
);

  localparam int CW = (CNT_W > TOUT_W) ? CNT_W : TOUT_W;

  logic [CW-1:0] cnt;
  logic [CW:0]   cntInc;
  logic [CW:0]   selLim;
  logic [CW:0]   pulseLim;
  logic [CW:0]   toutLim;

  assign cntInc   = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign selLim   = {{(CW + 1 - CNT_W){1'b0}}, cfgSelLow};
  assign pulseLim = {{(CW + 1 - CNT_W){1'b0}}, cfgPulse};
  assign toutLim  = {{(CW + 1 - TOUT_W){1'b0}}, cfgTimeout};

  // A phase ends on the cycle whose 1-based index reaches its limit.
  // A limit of zero therefore ends the phase after one cycle.
  assign hitSel   = (cntInc >= selLim);
  assign hitPulse = (cntInc >= pulseLim);
  assign hitTout  = (cntInc >= toutLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.cntClr) begin
      cnt <= '0;
    end else if (cnt != {CW{1'b1}}) begin
      cnt <= cntInc[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStrobe  <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      doneStrobe <= ctrl.doneSet;
      if (ctrl.toutSet) begin
        timeoutFlag <= 1'b1;
      end else if (ctrl.toutClr) begin
        timeoutFlag <= 1'b0;
      end
    end
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  // R7
  tout_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> doneStrobe);

endmodule

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      lineIn,
  input  logic      hitSel,
  input  logic      hitPulse,
  input  logic      hitTout,
  output seq_ctrl_t ctrl,
  output logic      selOut,
  output logic      clkOut,
  output logic      lineEn
);

  seq_state_e state;
  seq_state_e stateNext;
  logic       initPhase;

  always_comb begin
    stateNext    = state;
    ctrl.doneSet = 1'b0;
    ctrl.toutSet = 1'b0;
    ctrl.toutClr = 1'b0;
    case (state)
      ST_INIT: begin
        stateNext = ST_PWR_SET;
      end
      ST_PWR_SET: begin
        if (hitPulse) stateNext = ST_CLK_HI;
      end
      ST_IDLE: begin
        if (startReq) begin
          stateNext    = ST_SEL_LOW;
          ctrl.toutClr = 1'b1;
        end
      end
      ST_SEL_LOW: begin
        if (hitSel) stateNext = ST_POLL;
      end
      ST_POLL: begin
        if (lineIn) begin
          stateNext = ST_CLK_HI;
        end else if (hitTout) begin
          stateNext    = ST_IDLE;
          ctrl.doneSet = 1'b1;
          ctrl.toutSet = 1'b1;
        end
      end
      ST_CLK_HI: begin
        if (hitPulse) stateNext = ST_CLK_LO;
      end
      ST_CLK_LO: begin
        if (hitPulse) begin
          stateNext    = ST_IDLE;
          ctrl.doneSet = !initPhase;
        end
      end
      default: stateNext = ST_INIT;
    endcase
    ctrl.cntClr = (stateNext != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_INIT;
      initPhase <= 1'b1;
    end else begin
      state <= stateNext;
      if (state == ST_CLK_LO && hitPulse) initPhase <= 1'b0;
    end
  end

  assign selOut = (state == ST_PWR_SET) || (state == ST_POLL) ||
                  (state == ST_CLK_HI)  || (state == ST_CLK_LO);
  assign clkOut = (state == ST_CLK_HI);
  assign lineEn = (state == ST_IDLE);

  // R5
  clk_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkOut |-> selOut);

  // R8
  line_en_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineEn |-> (!selOut && !clkOut));

  // R3
  sel_low_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEL_LOW && !hitSel) |=> (state == ST_SEL_LOW));

  // R4
  ready_to_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POLL && lineIn) |=> clkOut);

  // R9
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_SEL_LOW) |=> (state != ST_SEL_LOW));

endmodule

// File: rtl/prog_cycle_seq.sv
module prog_cycle_seq
  import prog_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TOUT_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  cfgSelLow,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [TOUT_W-1:0] cfgTimeout,
  input  logic              lineIn,
  output logic              selOut,
  output logic              clkOut,
  output logic              lineEn,
  output logic              doneStrobe,
  output logic              timeoutFlag
);

  seq_ctrl_t ctrl;
  logic      hitSel;
  logic      hitPulse;
  logic      hitTout;

  prog_seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .lineIn   (lineIn),
    .hitSel   (hitSel),
    .hitPulse (hitPulse),
    .hitTout  (hitTout),
    .ctrl     (ctrl),
    .selOut   (selOut),
    .clkOut   (clkOut),
    .lineEn   (lineEn)
  );

  prog_seq_dp #(
    .CNT_W  (CNT_W),
    .TOUT_W (TOUT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .cfgSelLow   (cfgSelLow),
    .cfgPulse    (cfgPulse),
    .cfgTimeout  (cfgTimeout),
    .hitSel      (hitSel),
    .hitPulse    (hitPulse),
    .hitTout     (hitTout),
    .doneStrobe  (doneStrobe),
    .timeoutFlag (timeoutFlag)
  );

  // R6
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (lineEn && !selOut));

endmodule

// File: tb/test_prog_cycle_seq.sv
`timescale 1ns/1ps
module test_prog_cycle_seq;

  localparam int CNT_W  = 8;
  localparam int TOUT_W = 12;
  localparam int NVEC   = 7;
  // Vector fields: select-low, pulse, timeout, ready delay (poll cycles).
  localparam int VEC [NVEC][4] = '{
    '{3, 2, 10, 4},
    '{5, 1, 8, 1},
    '{2, 3, 6, 6},
    '{2, 2, 5, 9},
    '{4, 1, 4, 2},
    '{0, 0, 3, 2},
    '{1, 4, 20, 15}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic lineIn = 1'b0;
  logic [CNT_W-1:0]  cfgSelLow = '0;
  logic [CNT_W-1:0]  cfgPulse = '0;
  logic [TOUT_W-1:0] cfgTimeout = '0;
  logic selOut, clkOut, lineEn, doneStrobe, timeoutFlag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  prog_cycle_seq #(.CNT_W(CNT_W), .TOUT_W(TOUT_W)) i_prog_cycle_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .cfgSelLow(cfgSelLow), .cfgPulse(cfgPulse), .cfgTimeout(cfgTimeout),
    .lineIn(lineIn), .selOut(selOut), .clkOut(clkOut), .lineEn(lineEn),
    .doneStrobe(doneStrobe), .timeoutFlag(timeoutFlag)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic runSeq(input int sl, input int pu, input int to, input int dl,
                        input bit strayStart);
    int lowRun = 0, highRun = 0, clkHi = 0, rises = 0, lowAfter = 0;
    int dones = 0, hiCnt = 0, n = 0;
    bit sawHigh = 0, cancelled = 0, prevClk = 0, firstTout;
    bit expTout;
    expTout = (dl > eff(to));
    @(negedge clk);
    cfgSelLow  = CNT_W'(sl);
    cfgPulse   = CNT_W'(pu);
    cfgTimeout = TOUT_W'(to);
    lineIn     = 1'b0;
    startReq   = 1'b1;
    @(negedge clk);
    startReq  = 1'b0;
    firstTout = timeoutFlag;
    while (!lineEn && n < 2000) begin
      if (!selOut && !sawHigh) lowRun++;
      if (selOut) sawHigh = 1;
      if (selOut && !clkOut && rises == 0) highRun++;
      if (clkOut) clkHi++;
      if (clkOut && !prevClk) rises++;
      prevClk = clkOut;
      if (selOut && !clkOut && rises > 0) lowAfter++;
      if (doneStrobe) dones++;
      if (clkOut) cancelled = 1;
      if (selOut && !cancelled) hiCnt++;
      lineIn   = selOut && !cancelled && (hiCnt >= dl);
      startReq = strayStart && (n == 1);
      n++;
      @(negedge clk);
    end
    startReq = 1'b0;
    lineIn   = 1'b0;
    chk(firstTout == 0, "R7 flag cleared by start", firstTout, 0);
    chk(lowRun == eff(sl), "R3/R10 select-low length", lowRun, eff(sl));
    if (expTout) begin
      chk(highRun == eff(to), "R7 poll length at timeout", highRun, eff(to));
      chk(rises == 0, "R7 no clock on timeout", rises, 0);
    end else begin
      chk(highRun == dl, "R4 poll ends on ready", highRun, dl);
      chk(rises == 1 && clkHi == eff(pu), "R5 clock high width", clkHi, eff(pu));
      chk(lowAfter == eff(pu), "R5 low time before select drops", lowAfter, eff(pu));
    end
    chk(dones == 0 && doneStrobe == 1, "R6 done at idle entry", doneStrobe, 1);
    chk(timeoutFlag == expTout, "R7 timeout flag", timeoutFlag, int'(expTout));
    chk(lineEn == 1 && selOut == 0, "R8 line enable when idle", lineEn, 1);
    @(negedge clk);
    chk(doneStrobe == 0, "R6 done lasts one cycle", doneStrobe, 0);
    chk(timeoutFlag == expTout, "R7 flag held", timeoutFlag, int'(expTout));
    if (strayStart) begin
      repeat (4) @(negedge clk);
      chk(selOut == 0 && lineEn == 1, "R9 stray start ignored", selOut, 0);
    end
  endtask

  initial begin
    int selHigh = 0, clkBefore = 0, clkHi = 0, rises = 0, dones = 0, n = 0;
    bit prevClk = 0;
    cfgPulse = 8'd3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(selOut == 0 && clkOut == 0, "R1 select/clock in reset", selOut, 0);
    chk(lineEn == 0, "R1 line enable in reset", lineEn, 0);
    chk(doneStrobe == 0 && timeoutFlag == 0, "R1 done/flag in reset", doneStrobe, 0);
    lineIn = 1'b1;  // status driver active at power-up
    rstN   = 1'b1;
    while (!lineEn && n < 500) begin
      if (selOut) selHigh++;
      if (selOut && !clkOut && rises == 0) clkBefore++;
      if (clkOut) clkHi++;
      if (clkOut && !prevClk) rises++;
      prevClk = clkOut;
      if (doneStrobe) dones++;
      if (clkOut) lineIn = 1'b0;
      n++;
      @(negedge clk);
    end
    lineIn = 1'b0;
    chk(clkBefore == 3, "R2 select before power-up pulse", clkBefore, 3);
    chk(rises == 1 && clkHi == 3, "R2 power-up pulse width", clkHi, 3);
    chk(selHigh == 9, "R2 total select-high time", selHigh, 9);
    chk(dones == 0 && doneStrobe == 0, "R2 no done after power-up", doneStrobe, 0);

    for (int i = 0; i < NVEC; i++) begin
      runSeq(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], (i == 6));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule